// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Detector

This block is the bus-master side of the initialization handshake on a single-wire open-drain bus. Software writes a one to the start bit through a simple register-style port. The engine then pulls the wire low for a long reset pulse and releases it. At one fixed instant after the release it samples the wire to find out whether any slave is answering with a presence pulse. A slave answers after waiting 15 to 60 µs and holds the wire low for 60 to 240 µs.

A low level at the sample instant sets a latched presence flag. A presence result only means that at least one device is on the wire; software finds out how many there are. At a fixed point after the release, the hardware clears the start bit and raises a done strobe for one cycle. All timing counts microsecond ticks. A programmable prescaler produces these ticks from the system clock, using a divide value applied at an input. The wire input passes through a two-flop synchronizer before it is sampled.

Top module: `ow_init_master`

## Requirements
- R1: A synchronous reset, whether idle or in the middle of a sequence, releases the wire (`line_oe`=0) and clears `start_bit`, `present` and `done_pulse` by the next clock edge.
- R2: A write (`wr_en`=1) with `wr_start`=1 while idle sets `start_bit` at the next edge, clears `present` and starts driving the wire low. A write with `wr_start`=0 while idle has no effect.
- R3: The wire is driven low (`line_oe`=1) for exactly RESET_US ticks, which is 511 µs by default and at least 480 µs, and is then released.
- R4: One microsecond tick lasts `div_val`+1 clock cycles. The prescaler restarts when a sequence starts, so every interval in the sequence scales by exactly that factor.
- R5: `present` is decided only at the SAMPLE_US-th tick after release (68 µs by default). A low synchronized wire at that instant sets it, and a high one leaves it at 0. Low levels that end before that instant or begin after it have no effect.
- R6: `start_bit` clears by itself END_US ticks after release (512 µs by default). `done_pulse` is high for exactly one cycle, in the same cycle in which `start_bit` falls.
- R7: A start write while a sequence runs is ignored. The sequence keeps its original length and the presence result is kept.
- R8: `present` holds its value while idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_val | input | DIV_W | Prescaler divide value; a tick lasts div_val+1 clocks |
| wr_en | input | 1 | Control register write strobe |
| wr_start | input | 1 | Data for the start bit on a write |
| start_bit | output | 1 | Start/busy bit readback; clears by itself |
| present | output | 1 | Latched presence result |
| done_pulse | output | 1 | One-cycle strobe at sequence end |
| line_oe | output | 1 | Open-drain enable; 1 pulls the wire low |
| line_in | input | 1 | Raw wire level |

## Verification
The assertions assume that `div_val` stays constant while a sequence runs, and that `line_in` is a plain level that can settle at any cycle, because the synchronizer absorbs its timing. The bench changes `div_val` only while the block is idle. Its slave model drives the wire only after `line_oe` has been released, which matches open-drain behaviour. Every presence window the model uses ends or begins at least a few microseconds away from the sample instant, so that the two-cycle synchronizer delay cannot change the expected result.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_LISTEN = 2'd2
    } owm_state_e;
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick = (cnt_q == div_val);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (restart || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // ticks are never back to back unless the divide value is zero
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && div_val != '0 && $stable(div_val)) |=> !tick);
endmodule

// File: rtl/owm_sync2.sv
module owm_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/ow_init_master.sv
module ow_init_master #(
    parameter int DIV_W     = 8,
    parameter int RESET_US  = 511,
    parameter int SAMPLE_US = 68,
    parameter int END_US    = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_val,
    input  logic             wr_en,
    input  logic             wr_start,
    output logic             start_bit,
    output logic             present,
    output logic             done_pulse,
    output logic             line_oe,
    input  logic             line_in
);
    import owm_pkg::*;

    localparam int MAX_US = (RESET_US > END_US) ? RESET_US : END_US;
    localparam int US_W   = $clog2(MAX_US + 1);
    localparam logic [US_W-1:0] LOW_LAST    = US_W'(RESET_US - 1);
    localparam logic [US_W-1:0] SAMPLE_LAST = US_W'(SAMPLE_US - 1);
    localparam logic [US_W-1:0] END_LAST    = US_W'(END_US - 1);

    typedef struct packed {
        owm_state_e      state;
        logic [US_W-1:0] us;
        logic            present;
        logic            start;
        logic            done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic tick;
    logic go;
    logic line_s;

    owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (go),
        .div_val (div_val),
        .tick    (tick)
    );

    owm_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_s)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        go         = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (wr_en && wr_start) begin
                    ctl_d.state   = ST_LOW;
                    ctl_d.us      = '0;
                    ctl_d.present = 1'b0;
                    ctl_d.start   = 1'b1;
                    go            = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (ctl_q.us == LOW_LAST) begin
                        ctl_d.state = ST_LISTEN;
                        ctl_d.us    = '0;
                    end else begin
                        ctl_d.us = ctl_q.us + 1'b1;
                    end
                end
            end
            ST_LISTEN: begin
                if (tick) begin
                    if (ctl_q.us == SAMPLE_LAST && !line_s)
                        ctl_d.present = 1'b1;
                    if (ctl_q.us == END_LAST) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.us    = '0;
                        ctl_d.start = 1'b0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.us = ctl_q.us + 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.us      <= '0;
            ctl_q.present <= 1'b0;
            ctl_q.start   <= 1'b0;
            ctl_q.done    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_bit  = ctl_q.start;
    assign present    = ctl_q.present;
    assign done_pulse = ctl_q.done;
    assign line_oe    = (ctl_q.state == ST_LOW);

    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> (!line_oe && !start_bit && !present && !done_pulse));

    assert_start_clears_present_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(start_bit) |-> (!present && line_oe));

    assert_drive_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        line_oe |-> start_bit);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (!start_bit && $past(start_bit))) ;

    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (start_bit && !line_oe && wr_en) |=> (!line_oe && (start_bit || done_pulse)));

    assert_present_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!start_bit && !(wr_en && wr_start)) |=> $stable(present));
endmodule

// File: tb/sim_ow_init_master.sv
module sim_ow_init_master;
    localparam int RESET_US = 511;
    localparam int END_US   = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_val = 8'd0;
    logic       wr_en = 1'b0;
    logic       wr_start = 1'b0;
    logic       start_bit, present, done_pulse, line_oe;
    logic       line_in;

    int n_chk = 0;
    int n_bad = 0;

    // slave model
    logic slave_en = 1'b0;
    int   s_wait = 0;
    int   s_len  = 0;
    int   cur_div = 0;
    int   cyc = 0;
    logic armed = 1'b0;
    logic slave_low = 1'b0;

    always #10 clk = ~clk;

    assign line_in = !(line_oe || slave_low);

    ow_init_master u0 (
        .clk(clk), .rst(rst), .div_val(div_val), .wr_en(wr_en), .wr_start(wr_start),
        .start_bit(start_bit), .present(present), .done_pulse(done_pulse),
        .line_oe(line_oe), .line_in(line_in)
    );

    always @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0; cyc <= 0; slave_low <= 1'b0;
        end else if (line_oe) begin
            armed <= 1'b1; cyc <= 0; slave_low <= 1'b0;
        end else if (armed) begin
            cyc <= cyc + 1;
            slave_low <= slave_en && (cyc >= s_wait*(cur_div+1)) &&
                         (cyc < (s_wait+s_len)*(cur_div+1));
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one full sequence with counting; inj >= 0 writes start again at that count
    task automatic run_seq(input int d, input bit en, input int w, input int l,
                           input bit exp_p, input int inj, input string tag);
        int n_oe, n_st, n;
        div_val = 8'(d); cur_div = d;
        slave_en = en; s_wait = w; s_len = l;
        @(negedge clk); wr_en = 1'b1; wr_start = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_start = 1'b0;
        chk(start_bit == 1'b1 && present == 1'b0 && line_oe == 1'b1, {tag, " R2 start"},
            int'({start_bit, present, line_oe}), 3'b101);
        n_oe = 0; n_st = 0; n = 0;
        while (start_bit && n < 300000) begin
            if (line_oe) n_oe++;
            n_st++;
            if (n == inj) begin wr_en = 1'b1; wr_start = 1'b1; end
            if (n == inj + 1) begin wr_en = 1'b0; wr_start = 1'b0; end
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0; wr_start = 1'b0;
        chk(n_oe == RESET_US*(d+1), {tag, " R3/R4 low length"}, n_oe, RESET_US*(d+1));
        chk(n_st == (RESET_US+END_US)*(d+1), {tag, " R6/R4/R7 busy length"}, n_st,
            (RESET_US+END_US)*(d+1));
        chk(done_pulse == 1'b1, {tag, " R6 done with clear"}, done_pulse, 1);
        chk(present == exp_p, {tag, " R5 presence"}, present, exp_p);
        @(negedge clk);
        chk(done_pulse == 1'b0, {tag, " R6 done one cycle"}, done_pulse, 0);
        slave_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(!line_oe && !start_bit && !present && !done_pulse, "R1 reset state",
            int'({line_oe, start_bit, present, done_pulse}), 0);
    endtask

    task automatic t_no_slave();     run_seq(0, 1'b0, 0, 0, 1'b0, -1, "noslave"); endtask
    task automatic t_fast_slave();   run_seq(4, 1'b1, 15, 60, 1'b1, -1, "fast"); endtask
    task automatic t_slow_slave();   run_seq(4, 1'b1, 60, 240, 1'b1, -1, "slow"); endtask
    task automatic t_early_glitch(); run_seq(4, 1'b1, 20, 44, 1'b0, -1, "early"); endtask
    task automatic t_late_low();     run_seq(4, 1'b1, 72, 100, 1'b0, -1, "late"); endtask

    task automatic t_busy_write();
        run_seq(1, 1'b1, 30, 100, 1'b1, 100, "busylow R7");
        run_seq(1, 1'b1, 30, 100, 1'b1, 1500, "busylisten R7");
    endtask

    task automatic t_latch_and_clear();
        repeat (100) @(negedge clk);
        chk(present == 1'b1, "R8 present held", present, 1);
        @(negedge clk); wr_en = 1'b1; wr_start = 1'b0;
        @(negedge clk); wr_en = 1'b0;
        chk(!start_bit && present && !line_oe, "R2 zero write ignored",
            int'({start_bit, present, line_oe}), 3'b010);
        run_seq(0, 1'b0, 0, 0, 1'b0, -1, "clearnew");
    endtask

    task automatic t_mid_reset();
        div_val = 8'd2; cur_div = 2;
        @(negedge clk); wr_en = 1'b1; wr_start = 1'b1;
        @(negedge clk); wr_en = 1'b0; wr_start = 1'b0;
        repeat (50) @(negedge clk);
        chk(line_oe == 1'b1, "R1 pre-reset busy", line_oe, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!line_oe && !start_bit && !present && !done_pulse, "R1 mid-sequence reset",
            int'({line_oe, start_bit, present, done_pulse}), 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk(!line_oe && !start_bit, "R1 stays idle", int'({line_oe, start_bit}), 0);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below %0d", wd, 190000);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_slave();
        t_fast_slave();
        t_latch_and_clear();
        t_slow_slave();
        t_early_glitch();
        t_late_low();
        t_busy_write();
        t_mid_reset();
        summary();
    end
endmodule